// File: doc/BRIEF.md
# I2C Offload Transaction Generator

This block runs a whole I2C transfer of one to eight bytes, read or write, from a single write to its control register. Software first loads up to 64 bits of transmit data into two 32-bit words. It then writes the control word, which gives the direction, a 7-bit or 10-bit target address and the byte count. From there the sequencer steps through start, address, data and stop on its own, with no help from software between bytes.

The sequencer does not drive the bus pins. It hands one command at a time to a byte-level bus engine: a start, a stop, a byte write, or a byte read with a chosen acknowledge. It waits for the engine's completion pulse before it moves on. The engine reports three things back: the target's acknowledge, lost arbitration, and received bytes. Received bytes are packed little-endian into two 32-bit words. At the end of a transfer the block raises an interrupt-cause flag, and it sets an error flag if the transfer failed.

Top module: `i2c_offload_gen`

## Requirements
- R1: After reset every register reads as zero, `irq_o` is low and `cmd_valid_o` is low.
- R2: A write to the control word (offset 0xD0) launches a transfer only when the block is idle, bit 19 is set, and exactly one of bit 0 (write) or bit 1 (read) is set. The first command of a transfer is START. Any other control write starts no command.
- R3: With bit 12 clear (7-bit mode), the address byte is {addr[6:0], dir}, where addr is control bits [11:2] and dir is 0 for write and 1 for read. Command codes are START=0, WRITE=1, READ=2, STOP=3.
- R4: With bit 12 set (10-bit mode), the block sends {5'b11110, addr[9:8], 0} and then addr[7:0]. A read then issues a second START, then {5'b11110, addr[9:8], 1}.
- R5: A write sends (bits [15:13] + 1) data bytes and then STOP. Byte k comes from bits [8k+7:8k] of the low transmit word (0xC0) for k < 4, and from the high word (0xC4) for k >= 4.
- R6: A read issues (bits [18:16] + 1) READ commands. `cmd_nack_o` is 1 only on the last of them. Byte k is stored little-endian in the receive words (0xC8 low, 0xCC high). Bytes the transfer does not receive read as zero, because the receive words are cleared at launch.
- R7: A target NACK on any WRITE command (address or data) makes the next command STOP. It also sets status bit 0 (0xD4), which is cleared at launch.
- R8: Lost arbitration reported with a completion ends the transfer with no further command. It sets status bit 0 and cause bit 0.
- R9: Cause bit 0 (0xD8) sets on the cycle after the final STOP completes. `irq_o` equals cause bit 0 AND mask bit 0 (0xDC). Writing 0 to the cause word clears it.
- R10: While a transfer runs, control writes with bit 19 set and writes to either transmit word are ignored.
- R11: A control write with bit 19 clear during a transfer returns the sequencer to idle. `cmd_valid_o` is low from the next cycle, and the cause flag is not set.
- R12: A presented command holds its code, byte and NACK flag stable until `eng_done_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 8 | Register byte offset |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for `reg_addr_i` (combinational) |
| irq_o | output | 1 | Interrupt: cause AND mask |
| cmd_valid_o | output | 1 | Command to the bus engine is presented |
| cmd_op_o | output | 2 | Command code: START=0, WRITE=1, READ=2, STOP=3 |
| cmd_data_o | output | 8 | Byte to transmit for WRITE |
| cmd_nack_o | output | 1 | For READ, answer the byte with NACK |
| eng_done_i | input | 1 | Engine completed the presented command (one-cycle pulse) |
| eng_ack_i | input | 1 | Target acknowledged the written byte |
| eng_arb_lost_i | input | 1 | Arbitration was lost during the command |
| eng_rdata_i | input | 8 | Byte received by a READ |

## Verification
A wrong sequencer state shows at the command port on the next engine completion: an address byte with the wrong direction bit, a missing second START in 10-bit reads, or a STOP that comes too early or too late. A wrong byte index shows as a wrong transmit byte or a misplaced receive lane, visible at the command port or in the receive words. A lost end-of-transfer shows as `irq_o` never rising. A stuck or wrongly set error flag shows in the status word read right after the transfer. Aborts and ignored writes are checked through the command stream and the read-back of the transmit word.

// File: rtl/i2c_tg_pkg.sv
package i2c_tg_pkg;
  localparam int TG_MAX_BYTES = 8;
  localparam int TG_LEN_W     = $clog2(TG_MAX_BYTES);
  localparam int TG_BUF_W     = TG_MAX_BYTES * 8;

  // control word field positions (software-visible)
  localparam int CTL_WR       = 0;
  localparam int CTL_RD       = 1;
  localparam int CTL_ADDR_LSB = 2;
  localparam int CTL_TEN      = 12;
  localparam int CTL_TXL_LSB  = 13;
  localparam int CTL_RXL_LSB  = 16;
  localparam int CTL_EN       = 19;

  typedef enum logic [1:0] {
    OP_START = 2'd0,
    OP_WRITE = 2'd1,
    OP_READ  = 2'd2,
    OP_STOP  = 2'd3
  } tg_op_e;

  typedef enum logic [2:0] {
    S_IDLE, S_START, S_ADDR1, S_ADDR2, S_RSTART, S_ADDR1R, S_DATA, S_STOP
  } tg_state_e;

  typedef struct packed {
    logic                rd;
    logic                ten;
    logic [9:0]          addr;
    logic [TG_LEN_W-1:0] last;
  } tg_job_t;
endpackage

// File: rtl/i2c_tg_regs.sv
module i2c_tg_regs
  import i2c_tg_pkg::*;
#(
  parameter int AW = 8,
  parameter logic [AW-1:0] OFS_TX_LO = 'hC0,
  parameter logic [AW-1:0] OFS_TX_HI = 'hC4,
  parameter logic [AW-1:0] OFS_RX_LO = 'hC8,
  parameter logic [AW-1:0] OFS_RX_HI = 'hCC,
  parameter logic [AW-1:0] OFS_CTRL  = 'hD0,
  parameter logic [AW-1:0] OFS_STAT  = 'hD4,
  parameter logic [AW-1:0] OFS_CAUSE = 'hD8,
  parameter logic [AW-1:0] OFS_MASK  = 'hDC
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_i,
  input  logic [AW-1:0]       addr_i,
  input  logic [31:0]         wdata_i,
  output logic [31:0]         rdata_o,
  input  logic                busy_i,
  input  logic                end_i,
  input  logic                fail_i,
  input  logic [TG_BUF_W-1:0] rx_i,
  output logic                launch_o,
  output logic                cancel_o,
  output tg_job_t             job_o,
  output logic [TG_BUF_W-1:0] tx_o,
  output logic                irq_o
);
  logic [31:0] tx_lo_q, tx_hi_q, ctrl_q;
  logic        cause_q, mask_q, err_q;
  logic        sel_ctl;

  assign sel_ctl  = wr_i && (addr_i == OFS_CTRL);
  assign launch_o = sel_ctl && !busy_i && wdata_i[CTL_EN] &&
                    (wdata_i[CTL_WR] ^ wdata_i[CTL_RD]);
  assign cancel_o = sel_ctl && busy_i && !wdata_i[CTL_EN];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_lo_q <= '0;
      tx_hi_q <= '0;
      ctrl_q  <= '0;
      cause_q <= 1'b0;
      mask_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      if (wr_i && !busy_i && addr_i == OFS_TX_LO) tx_lo_q <= wdata_i;
      if (wr_i && !busy_i && addr_i == OFS_TX_HI) tx_hi_q <= wdata_i;
      // while busy only a disabling write lands
      if (sel_ctl && (!busy_i || !wdata_i[CTL_EN])) ctrl_q <= wdata_i;
      if (wr_i && addr_i == OFS_MASK) mask_q <= wdata_i[0];
      if (end_i)                                 cause_q <= 1'b1;
      else if (wr_i && addr_i == OFS_CAUSE)      cause_q <= wdata_i[0];
      if (fail_i)        err_q <= 1'b1;
      else if (launch_o) err_q <= 1'b0;
    end
  end

  always_comb begin
    job_o.rd   = ctrl_q[CTL_RD];
    job_o.ten  = ctrl_q[CTL_TEN];
    job_o.addr = ctrl_q[CTL_ADDR_LSB +: 10];
    job_o.last = ctrl_q[CTL_RD] ? ctrl_q[CTL_RXL_LSB +: TG_LEN_W]
                                : ctrl_q[CTL_TXL_LSB +: TG_LEN_W];
  end

  assign tx_o  = {tx_hi_q, tx_lo_q};
  assign irq_o = cause_q & mask_q;

  always_comb begin
    unique case (addr_i)
      OFS_TX_LO: rdata_o = tx_lo_q;
      OFS_TX_HI: rdata_o = tx_hi_q;
      OFS_RX_LO: rdata_o = rx_i[31:0];
      OFS_RX_HI: rdata_o = rx_i[63:32];
      OFS_CTRL:  rdata_o = ctrl_q;
      OFS_STAT:  rdata_o = {31'd0, err_q};
      OFS_CAUSE: rdata_o = {31'd0, cause_q};
      OFS_MASK:  rdata_o = {31'd0, mask_q};
      default:   rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/i2c_tg_rxbuf.sv
module i2c_tg_rxbuf
  import i2c_tg_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                clear_i,
  input  logic                we_i,
  input  logic [TG_LEN_W-1:0] idx_i,
  input  logic [7:0]          byte_i,
  output logic [TG_BUF_W-1:0] data_o
);
  for (genvar k = 0; k < TG_MAX_BYTES; k++) begin : g_lane
    logic [7:0] lane_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                    lane_q <= '0;
      else if (clear_i)                               lane_q <= '0;
      else if (we_i && idx_i == TG_LEN_W'(k))         lane_q <= byte_i;
    end
    assign data_o[8*k +: 8] = lane_q;
  end
endmodule

// File: rtl/i2c_tg_seq.sv
module i2c_tg_seq
  import i2c_tg_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                launch_i,
  input  logic                cancel_i,
  input  tg_job_t             job_i,
  input  logic [TG_BUF_W-1:0] tx_i,
  input  logic                eng_done_i,
  input  logic                eng_ack_i,
  input  logic                eng_arb_lost_i,
  input  logic [7:0]          eng_rdata_i,
  output logic                cmd_valid_o,
  output tg_op_e              cmd_op_o,
  output logic [7:0]          cmd_data_o,
  output logic                cmd_nack_o,
  output logic                busy_o,
  output logic                end_o,
  output logic                fail_o,
  output logic                rx_we_o,
  output logic [TG_LEN_W-1:0] rx_idx_o,
  output logic [7:0]          rx_byte_o
);
  tg_state_e           state_q, state_d;
  logic [TG_LEN_W-1:0] idx_q, idx_d;
  logic                last_byte;
  logic [7:0]          hdr_w, hdr_r;

  assign last_byte = (idx_q == job_i.last);
  assign hdr_w     = {5'b11110, job_i.addr[9:8], 1'b0};
  assign hdr_r     = {5'b11110, job_i.addr[9:8], 1'b1};

  always_comb begin
    cmd_valid_o = (state_q != S_IDLE);
    cmd_op_o    = OP_WRITE;
    cmd_data_o  = '0;
    cmd_nack_o  = 1'b0;
    unique case (state_q)
      S_IDLE, S_START, S_RSTART: cmd_op_o = OP_START;
      S_ADDR1:  cmd_data_o = job_i.ten ? hdr_w : {job_i.addr[6:0], job_i.rd};
      S_ADDR2:  cmd_data_o = job_i.addr[7:0];
      S_ADDR1R: cmd_data_o = hdr_r;
      S_DATA: begin
        if (job_i.rd) begin
          cmd_op_o   = OP_READ;
          cmd_nack_o = last_byte;
        end else begin
          cmd_data_o = tx_i[8*idx_q +: 8];
        end
      end
      S_STOP:   cmd_op_o = OP_STOP;
      default:  cmd_op_o = OP_START;
    endcase
  end

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    end_o   = 1'b0;
    fail_o  = 1'b0;
    rx_we_o = 1'b0;
    if (cancel_i) begin
      state_d = S_IDLE;
      idx_d   = '0;
    end else if (launch_i) begin
      state_d = S_START;
      idx_d   = '0;
    end else if (eng_done_i && state_q != S_IDLE) begin
      if (eng_arb_lost_i) begin
        // bus no longer ours: no STOP
        state_d = S_IDLE;
        end_o   = 1'b1;
        fail_o  = 1'b1;
      end else begin
        unique case (state_q)
          S_START:  state_d = S_ADDR1;
          S_ADDR1: begin
            if (!eng_ack_i)     begin state_d = S_STOP; fail_o = 1'b1; end
            else if (job_i.ten) state_d = S_ADDR2;
            else                state_d = S_DATA;
          end
          S_ADDR2: begin
            if (!eng_ack_i)    begin state_d = S_STOP; fail_o = 1'b1; end
            else if (job_i.rd) state_d = S_RSTART;
            else               state_d = S_DATA;
          end
          S_RSTART: state_d = S_ADDR1R;
          S_ADDR1R: begin
            if (!eng_ack_i) begin state_d = S_STOP; fail_o = 1'b1; end
            else            state_d = S_DATA;
          end
          S_DATA: begin
            if (job_i.rd) begin
              rx_we_o = 1'b1;
              if (last_byte) state_d = S_STOP;
              else           idx_d   = idx_q + 1'b1;
            end else if (!eng_ack_i) begin
              state_d = S_STOP;
              fail_o  = 1'b1;
            end else if (last_byte) begin
              state_d = S_STOP;
            end else begin
              idx_d = idx_q + 1'b1;
            end
          end
          S_STOP: begin
            state_d = S_IDLE;
            end_o   = 1'b1;
          end
          default: state_d = S_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      idx_q   <= '0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
    end
  end

  assign busy_o    = (state_q != S_IDLE);
  assign rx_idx_o  = idx_q;
  assign rx_byte_o = eng_rdata_i;
endmodule

// File: rtl/i2c_offload_gen.sv
module i2c_offload_gen
  import i2c_tg_pkg::*;
#(
  parameter int AW = 8,
  parameter logic [AW-1:0] OFS_TX_LO = 'hC0,
  parameter logic [AW-1:0] OFS_TX_HI = 'hC4,
  parameter logic [AW-1:0] OFS_RX_LO = 'hC8,
  parameter logic [AW-1:0] OFS_RX_HI = 'hCC,
  parameter logic [AW-1:0] OFS_CTRL  = 'hD0,
  parameter logic [AW-1:0] OFS_STAT  = 'hD4,
  parameter logic [AW-1:0] OFS_CAUSE = 'hD8,
  parameter logic [AW-1:0] OFS_MASK  = 'hDC
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          reg_wr_i,
  input  logic [AW-1:0] reg_addr_i,
  input  logic [31:0]   reg_wdata_i,
  output logic [31:0]   reg_rdata_o,
  output logic          irq_o,
  output logic          cmd_valid_o,
  output logic [1:0]    cmd_op_o,
  output logic [7:0]    cmd_data_o,
  output logic          cmd_nack_o,
  input  logic          eng_done_i,
  input  logic          eng_ack_i,
  input  logic          eng_arb_lost_i,
  input  logic [7:0]    eng_rdata_i
);
  logic                busy, seq_end, seq_fail, launch, cancel;
  logic                rx_we;
  logic [TG_LEN_W-1:0] rx_idx;
  logic [7:0]          rx_byte;
  logic [TG_BUF_W-1:0] tx_buf, rx_buf;
  tg_job_t             job;
  tg_op_e              seq_op;

  i2c_tg_regs #(
    .AW(AW), .OFS_TX_LO(OFS_TX_LO), .OFS_TX_HI(OFS_TX_HI),
    .OFS_RX_LO(OFS_RX_LO), .OFS_RX_HI(OFS_RX_HI), .OFS_CTRL(OFS_CTRL),
    .OFS_STAT(OFS_STAT), .OFS_CAUSE(OFS_CAUSE), .OFS_MASK(OFS_MASK)
  ) u_regs (
    .clk_i, .rst_ni,
    .wr_i(reg_wr_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i),
    .rdata_o(reg_rdata_o),
    .busy_i(busy), .end_i(seq_end), .fail_i(seq_fail), .rx_i(rx_buf),
    .launch_o(launch), .cancel_o(cancel), .job_o(job), .tx_o(tx_buf),
    .irq_o(irq_o)
  );

  i2c_tg_seq u_seq (
    .clk_i, .rst_ni,
    .launch_i(launch), .cancel_i(cancel), .job_i(job), .tx_i(tx_buf),
    .eng_done_i, .eng_ack_i, .eng_arb_lost_i, .eng_rdata_i,
    .cmd_valid_o, .cmd_op_o(seq_op), .cmd_data_o, .cmd_nack_o,
    .busy_o(busy), .end_o(seq_end), .fail_o(seq_fail),
    .rx_we_o(rx_we), .rx_idx_o(rx_idx), .rx_byte_o(rx_byte)
  );

  i2c_tg_rxbuf u_rxbuf (
    .clk_i, .rst_ni,
    .clear_i(launch), .we_i(rx_we), .idx_i(rx_idx), .byte_i(rx_byte),
    .data_o(rx_buf)
  );

  assign cmd_op_o = seq_op;
endmodule

// File: rtl/i2c_tg_checker.sv
module i2c_tg_checker
  import i2c_tg_pkg::*;
#(
  parameter int AW = 8,
  parameter logic [AW-1:0] CTRL_OFS = 'hD0
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          reg_wr_i,
  input logic [AW-1:0] reg_addr_i,
  input logic          ctl_en_i,
  input logic          busy_i,
  input logic          cmd_valid_i,
  input logic [1:0]    cmd_op_i,
  input logic [7:0]    cmd_data_i,
  input logic          cmd_nack_i,
  input logic          eng_done_i,
  input logic          eng_ack_i,
  input logic          eng_arb_lost_i,
  input logic          cause_i,
  input logic          err_i
);
  logic ctl_wr;
  assign ctl_wr = reg_wr_i && (reg_addr_i == CTRL_OFS);

  assert_cmd_hold_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_i && !eng_done_i && !ctl_wr |=>
      cmd_valid_i && $stable(cmd_op_i) && $stable(cmd_data_i) && $stable(cmd_nack_i));

  assert_first_start_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_i) |-> cmd_valid_i && cmd_op_i == OP_START);

  assert_nack_stop_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_i && cmd_op_i == OP_WRITE && eng_done_i && !eng_ack_i &&
    !eng_arb_lost_i && !ctl_wr |=> cmd_valid_i && cmd_op_i == OP_STOP && err_i);

  assert_stop_cause_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_i && cmd_op_i == OP_STOP && eng_done_i && !eng_arb_lost_i && !ctl_wr
      |=> cause_i && !cmd_valid_i);

  assert_arb_end_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_i && eng_done_i && eng_arb_lost_i && !ctl_wr
      |=> !cmd_valid_i && err_i && cause_i);

  assert_cancel_idle_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_wr && !ctl_en_i |=> !cmd_valid_i);
endmodule

bind i2c_offload_gen i2c_tg_checker u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni),
  .reg_wr_i(reg_wr_i), .reg_addr_i(reg_addr_i), .ctl_en_i(reg_wdata_i[19]),
  .busy_i(busy), .cmd_valid_i(cmd_valid_o), .cmd_op_i(cmd_op_o),
  .cmd_data_i(cmd_data_o), .cmd_nack_i(cmd_nack_o),
  .eng_done_i(eng_done_i), .eng_ack_i(eng_ack_i), .eng_arb_lost_i(eng_arb_lost_i),
  .cause_i(u_regs.cause_q), .err_i(u_regs.err_q)
);

// File: tb/i2c_offload_gen_bench.sv
`timescale 1ns/1ps
module i2c_offload_gen_bench;
  import i2c_tg_pkg::*;

  localparam logic [7:0] A_TXLO = 8'hC0, A_TXHI = 8'hC4, A_RXLO = 8'hC8, A_RXHI = 8'hCC;
  localparam logic [7:0] A_CTRL = 8'hD0, A_STAT = 8'hD4, A_CAUSE = 8'hD8, A_MASK = 8'hDC;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst_n, reg_wr;
  logic [7:0]  reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic        irq, cmd_valid, cmd_nack;
  logic [1:0]  cmd_op;
  logic [7:0]  cmd_data;
  logic        eng_done, eng_ack, eng_arb;
  logic [7:0]  eng_rdata;

  i2c_offload_gen u_i2c_offload_gen (
    .clk_i(clk), .rst_ni(rst_n),
    .reg_wr_i(reg_wr), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata),
    .reg_rdata_o(reg_rdata), .irq_o(irq),
    .cmd_valid_o(cmd_valid), .cmd_op_o(cmd_op), .cmd_data_o(cmd_data),
    .cmd_nack_o(cmd_nack),
    .eng_done_i(eng_done), .eng_ack_i(eng_ack), .eng_arb_lost_i(eng_arb),
    .eng_rdata_i(eng_rdata)
  );

  int checks = 0, errors = 0;
  bit finished = 0;

  // bus engine model and command log
  int n_cmds = 0, rd_cnt = 0, nack_at = -1, arb_at = -1, hold_cnt = 0, mism = 0;
  logic [1:0]  lop [32];
  logic [7:0]  ldat[32];
  logic        lnk [32];
  logic [10:0] held;

  initial begin
    eng_done = 0; eng_ack = 0; eng_arb = 0; eng_rdata = 0;
    forever begin
      @(negedge clk);
      eng_done = 0; eng_ack = 0; eng_arb = 0;
      if (cmd_valid) begin
        if (hold_cnt == 0) held = {cmd_op, cmd_data, cmd_nack};
        else if (held != {cmd_op, cmd_data, cmd_nack}) mism++;
        hold_cnt++;
        if (hold_cnt == 3) begin
          if (n_cmds < 32) begin
            lop[n_cmds] = cmd_op; ldat[n_cmds] = cmd_data; lnk[n_cmds] = cmd_nack;
          end
          eng_ack   = (n_cmds != nack_at);
          eng_arb   = (n_cmds == arb_at);
          eng_rdata = 8'hC0 + 8'(rd_cnt);
          if (cmd_op == OP_READ) rd_cnt++;
          n_cmds++;
          eng_done = 1;
          hold_cnt = 0;
        end
      end else hold_cnt = 0;
    end
  end

  // expected command list
  int e_n;
  logic [1:0] eop [32];
  logic [7:0] edat[32];
  logic       enk [32];

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic e_push(input logic [1:0] op, input logic [7:0] d, input logic nk);
    eop[e_n] = op; edat[e_n] = d; enk[e_n] = nk; e_n++;
  endtask

  task automatic cmp_log(input string req);
    chk(n_cmds == e_n, {req, " command count"}, 64'(n_cmds), 64'(e_n));
    for (int i = 0; i < e_n && i < n_cmds; i++)
      chk(lop[i] == eop[i] && ldat[i] == edat[i] && lnk[i] == enk[i],
          {req, " command"}, {53'd0, lop[i], ldat[i], lnk[i]},
          {53'd0, eop[i], edat[i], enk[i]});
  endtask

  task automatic reg_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic reg_read(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  function automatic logic [31:0] mk_ctrl(input bit wr, input bit rd, input logic [9:0] a,
                                          input bit ten, input int txm1, input int rxm1);
    return {12'd0, 1'b1, 3'(rxm1), 3'(txm1), ten, a, rd, wr};
  endfunction

  task automatic prep(input int nk, input int ar);
    reg_write(A_CAUSE, 0);
    n_cmds = 0; rd_cnt = 0; nack_at = nk; arb_at = ar; e_n = 0;
  endtask

  task automatic wait_end(input string req);
    int t = 0;
    while (!irq && t < 2000) begin @(negedge clk); t++; end
    chk(irq == 1'b1, {req, " completion irq"}, 64'(irq), 64'd1);
    repeat (3) @(negedge clk);
  endtask

  task automatic wait_cmds(input int n);
    int t = 0;
    while (n_cmds < n && t < 2000) begin @(negedge clk); t++; end
  endtask

  task automatic t_reset;
    logic [31:0] v;
    logic [7:0] al[8] = '{A_TXLO, A_TXHI, A_RXLO, A_RXHI, A_CTRL, A_STAT, A_CAUSE, A_MASK};
    foreach (al[i]) begin
      reg_read(al[i], v);
      chk(v == 0, "R1 register reset value", 64'(v), 64'd0);
    end
    chk(irq == 0 && cmd_valid == 0, "R1 irq/cmd_valid after reset", {irq, cmd_valid}, 0);
  endtask

  task automatic t_write7;
    logic [31:0] v;
    prep(-1, -1);
    reg_write(A_TXLO, 32'h44332211);
    reg_write(A_CTRL, mk_ctrl(1, 0, 10'h035, 0, 2, 0));
    wait_end("R5");
    e_push(OP_START, 0, 0); e_push(OP_WRITE, 8'h6A, 0);
    e_push(OP_WRITE, 8'h11, 0); e_push(OP_WRITE, 8'h22, 0); e_push(OP_WRITE, 8'h33, 0);
    e_push(OP_STOP, 0, 0);
    cmp_log("R3 R5 7-bit write");
    reg_read(A_STAT, v);
    chk(v == 0, "R7 status clean after good write", 64'(v), 0);
  endtask

  task automatic t_write10;
    prep(-1, -1);
    reg_write(A_TXLO, 32'h13121110);
    reg_write(A_TXHI, 32'h17161514);
    reg_write(A_CTRL, mk_ctrl(1, 0, 10'h2A5, 1, 7, 0));
    wait_end("R4");
    e_push(OP_START, 0, 0); e_push(OP_WRITE, 8'hF4, 0); e_push(OP_WRITE, 8'hA5, 0);
    for (int k = 0; k < 8; k++) e_push(OP_WRITE, 8'h10 + 8'(k), 0);
    e_push(OP_STOP, 0, 0);
    cmp_log("R4 R5 10-bit 8-byte write");
  endtask

  task automatic t_read7;
    logic [31:0] v;
    prep(-1, -1);
    reg_write(A_CTRL, mk_ctrl(0, 1, 10'h050, 0, 0, 4));
    wait_end("R6");
    e_push(OP_START, 0, 0); e_push(OP_WRITE, 8'hA1, 0);
    for (int k = 0; k < 5; k++) e_push(OP_READ, 0, k == 4);
    e_push(OP_STOP, 0, 0);
    cmp_log("R3 R6 7-bit read");
    reg_read(A_RXLO, v);
    chk(v == 32'hC3C2C1C0, "R6 rx low word", 64'(v), 64'hC3C2C1C0);
    reg_read(A_RXHI, v);
    chk(v == 32'h000000C4, "R6 rx high word", 64'(v), 64'hC4);
  endtask

  task automatic t_read10;
    logic [31:0] v;
    prep(-1, -1);
    reg_write(A_CTRL, mk_ctrl(0, 1, 10'h1F0, 1, 0, 1));
    wait_end("R4");
    e_push(OP_START, 0, 0); e_push(OP_WRITE, 8'hF2, 0); e_push(OP_WRITE, 8'hF0, 0);
    e_push(OP_START, 0, 0); e_push(OP_WRITE, 8'hF3, 0);
    e_push(OP_READ, 0, 0); e_push(OP_READ, 0, 1); e_push(OP_STOP, 0, 0);
    cmp_log("R4 10-bit read");
    reg_read(A_RXLO, v);
    chk(v == 32'h0000C1C0, "R6 rx low cleared at launch", 64'(v), 64'hC1C0);
    reg_read(A_RXHI, v);
    chk(v == 0, "R6 rx high cleared at launch", 64'(v), 0);
  endtask

  task automatic t_data_nack;
    logic [31:0] v;
    prep(3, -1);
    reg_write(A_TXLO, 32'hDDCCBBAA);
    reg_write(A_CTRL, mk_ctrl(1, 0, 10'h010, 0, 3, 0));
    wait_end("R7");
    e_push(OP_START, 0, 0); e_push(OP_WRITE, 8'h20, 0);
    e_push(OP_WRITE, 8'hAA, 0); e_push(OP_WRITE, 8'hBB, 0); e_push(OP_STOP, 0, 0);
    cmp_log("R7 data NACK");
    reg_read(A_STAT, v);
    chk(v == 1, "R7 status after data NACK", 64'(v), 1);
  endtask

  task automatic t_addr_nack;
    logic [31:0] v;
    prep(1, -1);
    reg_write(A_CTRL, mk_ctrl(0, 1, 10'h011, 0, 0, 3));
    wait_end("R7");
    e_push(OP_START, 0, 0); e_push(OP_WRITE, 8'h23, 0); e_push(OP_STOP, 0, 0);
    cmp_log("R7 address NACK");
    reg_read(A_STAT, v);
    chk(v == 1, "R7 status after address NACK", 64'(v), 1);
  endtask

  task automatic t_arb;
    logic [31:0] v;
    prep(-1, 2);
    reg_write(A_TXLO, 32'h00000055);
    reg_write(A_CTRL, mk_ctrl(1, 0, 10'h035, 0, 3, 0));
    wait_end("R8");
    repeat (10) @(negedge clk);
    e_push(OP_START, 0, 0); e_push(OP_WRITE, 8'h6A, 0); e_push(OP_WRITE, 8'h55, 0);
    cmp_log("R8 arbitration lost");
    reg_read(A_STAT, v);
    chk(v == 1, "R8 status after arbitration loss", 64'(v), 1);
  endtask

  task automatic t_invalid;
    prep(-1, -1);
    reg_write(A_CTRL, mk_ctrl(1, 1, 10'h035, 0, 0, 0));
    repeat (20) @(negedge clk);
    reg_write(A_CTRL, mk_ctrl(0, 0, 10'h035, 0, 0, 0));
    repeat (20) @(negedge clk);
    chk(n_cmds == 0 && cmd_valid == 0, "R2 invalid direction bits do not launch", 64'(n_cmds), 0);
    chk(irq == 0, "R2 no completion without launch", 64'(irq), 0);
  endtask

  task automatic t_busy_ignore;
    logic [31:0] v;
    prep(-1, -1);
    reg_write(A_TXLO, 32'hA3A2A1A0);
    reg_write(A_TXHI, 32'hA7A6A5A4);
    reg_write(A_CTRL, mk_ctrl(1, 0, 10'h035, 0, 7, 0));
    wait_cmds(2);
    reg_write(A_TXLO, 32'hFFFFFFFF);
    reg_write(A_CTRL, mk_ctrl(0, 1, 10'h07F, 0, 0, 0));
    wait_end("R10");
    e_push(OP_START, 0, 0); e_push(OP_WRITE, 8'h6A, 0);
    for (int k = 0; k < 8; k++) e_push(OP_WRITE, 8'hA0 + 8'(k), 0);
    e_push(OP_STOP, 0, 0);
    cmp_log("R10 writes during transfer ignored");
    reg_read(A_TXLO, v);
    chk(v == 32'hA3A2A1A0, "R10 tx word kept while busy", 64'(v), 64'hA3A2A1A0);
  endtask

  task automatic t_cancel;
    prep(-1, -1);
    reg_write(A_CTRL, mk_ctrl(1, 0, 10'h035, 0, 7, 0));
    wait_cmds(2);
    reg_write(A_CTRL, 32'd0);
    chk(cmd_valid == 0, "R11 command dropped after cancel", 64'(cmd_valid), 0);
    repeat (20) @(negedge clk);
    chk(cmd_valid == 0 && irq == 0, "R11 idle, no cause after cancel", {cmd_valid, irq}, 0);
  endtask

  task automatic t_irq;
    logic [31:0] v;
    prep(-1, -1);
    reg_write(A_CTRL, mk_ctrl(1, 0, 10'h001, 0, 0, 0));
    wait_end("R9");
    reg_read(A_CAUSE, v);
    chk(v == 1, "R9 cause set after transfer", 64'(v), 1);
    reg_write(A_MASK, 0);
    chk(irq == 0, "R9 irq masked", 64'(irq), 0);
    reg_write(A_MASK, 1);
    chk(irq == 1, "R9 irq unmasked", 64'(irq), 1);
    reg_write(A_CAUSE, 0);
    reg_read(A_CAUSE, v);
    chk(v == 0 && irq == 0, "R9 cause cleared by writing 0", {v, irq}, 0);
  endtask

  initial begin
    rst_n = 0; reg_wr = 0; reg_addr = 0; reg_wdata = 0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    reg_write(A_MASK, 1);
    t_write7();
    t_write10();
    t_read7();
    t_read10();
    t_data_nack();
    t_addr_nack();
    t_arb();
    t_invalid();
    t_busy_ignore();
    t_cancel();
    t_irq();
    chk(mism == 0, "R12 command stable until done", 64'(mism), 0);
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule